// File: doc/BRIEF.md
# Circular-Buffer DMA Pointer Engine

This block is the pointer and interrupt logic for a DMA channel whose memory side is a circular buffer. The buffer starts at a programmed base address and holds a power-of-two number of transfer units. The other side of every transfer is a fixed peripheral address. Two pointers index the buffer as offsets from the base. The hardware pointer moves one unit on each granted bus transfer. The software pointer is loaded by register writes.

A direction bit sets the roles of the pointers. When data flows from the peripheral into memory, hardware produces data and software consumes it. When data flows from memory to the peripheral, software fills the buffer and hardware drains it. From the two pointers the engine derives:
- the fill level;
- the full and empty conditions;
- the source and destination addresses of the next transfer;
- whether a transfer may be requested at all.

Two sticky interrupt flags report to software. The first compares the fill level with a programmed threshold, and the direction of that comparison flips with the transfer direction. The second reports that no data has entered the buffer for a programmed number of cycles.

Top module: `vfifo_ptr_engine`

## Requirements
- R1: After reset both pointers are zero, the fill level is zero, the buffer is empty and not full, and both interrupt flags are low.
- R2: Each cycle with `xfer_req` and `xfer_gnt` both high advances the hardware pointer by exactly one. The pointer has offset bits plus one wrap bit at bit position log2(DEPTH). When the offset passes DEPTH-1 it returns to zero and the wrap bit toggles. In any other cycle the hardware pointer holds.
- R3: With `cfg_dir`=0 (peripheral to memory), the fill level is hardware pointer minus software pointer, modulo 2·DEPTH. While the buffer is full, `xfer_req` stays low even when `per_req` is high.
- R4: With `cfg_dir`=1 (memory to peripheral), the fill level is software pointer minus hardware pointer. While the buffer is empty, `xfer_req` stays low even when `per_req` is high.
- R5: With `cfg_dir`=0 the transfer source is `cfg_fix_addr`, the destination is `cfg_base` + offset·UNIT_BYTES, and `xfer_to_mem` is 1. With `cfg_dir`=1 the source and destination swap and `xfer_to_mem` is 0. In both cases the offset is the hardware pointer without its wrap bit.
- R6: With `cfg_dir`=0 the threshold flag is set one cycle after a cycle in which the fill level is greater than or equal to `cfg_thresh`.
- R7: With `cfg_dir`=1 the threshold flag is set one cycle after a cycle in which the fill level is strictly less than `cfg_thresh`.
- R8: Both flags are sticky and cleared by writing 1 to their `irq_clr` bit: bit 0 clears the threshold flag and bit 1 clears the timeout flag. A clear only takes effect when the setting condition is false in that same cycle; a set and a clear in one cycle leave the flag set.
- R9: The idle counter restarts whenever data enters the buffer. Data enters on a granted transfer with `cfg_dir`=0, and on a software pointer write with `cfg_dir`=1. If T = `cfg_timeout` is nonzero, the timeout flag rises T cycles after the last entry, and only once per idle period.
- R10: With `cfg_timeout` = 0 the timeout flag never rises.
- R11: The buffer is empty when both pointers are equal including the wrap bit. It is full when the offsets are equal and the wrap bits differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dir | input | 1 | 0 = peripheral to memory, 1 = memory to peripheral |
| cfg_base | input | AW | Buffer base address |
| cfg_fix_addr | input | AW | Peripheral-side address |
| cfg_thresh | input | PW | Fill-level threshold |
| cfg_timeout | input | TW | Idle cycles before the timeout flag; 0 disables it |
| sw_ptr_wr | input | 1 | Load the software pointer |
| sw_ptr_wdata | input | PW | New software pointer (offset and wrap bit) |
| irq_clr | input | 2 | Write-1-to-clear: bit 0 threshold, bit 1 timeout |
| per_req | input | 1 | Peripheral wants one unit moved |
| xfer_gnt | input | 1 | Bus accepts the requested transfer |
| xfer_req | output | 1 | Transfer request to the bus |
| xfer_to_mem | output | 1 | 1 when the transfer writes memory |
| xfer_src | output | AW | Transfer source address |
| xfer_dst | output | AW | Transfer destination address |
| hw_ptr | output | PW | Hardware pointer (offset and wrap bit) |
| fill_level | output | PW | Units currently held in the buffer |
| fifo_full | output | 1 | Buffer full |
| fifo_empty | output | 1 | Buffer empty |
| irq_thr | output | 1 | Sticky threshold flag |
| irq_tmo | output | 1 | Sticky timeout flag |

## Verification
Two events can coincide in one cycle: a software clear of a flag, and the condition that sets that flag. The bench provokes this in two ways. It writes the threshold clear while the buffer is still full above the threshold. It also pulses the timeout clear in exactly the cycle the idle counter reaches its limit. In both cases the flag must read high afterwards. A clear issued once the condition is gone must then drop the flag.

// File: rtl/vfifo_pkg.sv
package vfifo_pkg;

    typedef enum logic {
        DIR_P2M = 1'b0,
        DIR_M2P = 1'b1
    } vf_dir_e;

    localparam int IRQ_THR_BIT = 0;
    localparam int IRQ_TMO_BIT = 1;

endpackage

// File: rtl/vfifo_ptr_ctl.sv
module vfifo_ptr_ctl
    import vfifo_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int AW         = 32,
    parameter int UNIT_BYTES = 4,
    localparam int OW = $clog2(DEPTH),
    localparam int PW = OW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  vf_dir_e       dir,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] fix_addr,
    input  logic          sw_wr,
    input  logic [PW-1:0] sw_wdata,
    input  logic          per_req,
    input  logic          gnt,
    output logic          req,
    output logic          to_mem,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [PW-1:0] hw_ptr,
    output logic [PW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          entry
);
    localparam int SH = $clog2(UNIT_BYTES);

    typedef struct packed {
        logic [PW-1:0] hw;
        logic [PW-1:0] sw;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [AW-1:0] mem_addr;
    logic          xfer;

    always_comb begin
        // Producer and consumer roles follow the direction bit
        wr_ptr   = (dir == DIR_P2M) ? st_q.hw : st_q.sw;
        rd_ptr   = (dir == DIR_P2M) ? st_q.sw : st_q.hw;
        level    = wr_ptr - rd_ptr;
        empty    = (wr_ptr == rd_ptr);
        full     = (wr_ptr[OW-1:0] == rd_ptr[OW-1:0]) && (wr_ptr[OW] != rd_ptr[OW]);
        req      = per_req && ((dir == DIR_P2M) ? !full : !empty);
        xfer     = req && gnt;
        entry    = (dir == DIR_P2M) ? xfer : sw_wr;
        mem_addr = base + (AW'(st_q.hw[OW-1:0]) << SH);
        to_mem   = (dir == DIR_P2M);
        src      = (dir == DIR_P2M) ? fix_addr : mem_addr;
        dst      = (dir == DIR_P2M) ? mem_addr : fix_addr;
        hw_ptr   = st_q.hw;

        st_d = st_q;
        if (xfer)  st_d.hw = st_q.hw + PW'(1);
        if (sw_wr) st_d.sw = sw_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: one granted transfer moves the hardware pointer by one
    p_hw_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && gnt) |=> (st_q.hw == $past(st_q.hw) + PW'(1)));

    // R2: no grant, no movement
    p_hw_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && gnt) |=> $stable(st_q.hw));

    // R3: a full buffer stays full until software frees space
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dir == DIR_P2M && full && !sw_wr) |=> full);

    // R4: an empty buffer stays empty until software adds data
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dir == DIR_M2P && empty && !sw_wr) |=> empty);

endmodule

// File: rtl/vfifo_irq_ctl.sv
module vfifo_irq_ctl
    import vfifo_pkg::*;
#(
    parameter int PW = 7,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  vf_dir_e       dir,
    input  logic [PW-1:0] level,
    input  logic [PW-1:0] thresh,
    input  logic [TW-1:0] tmo_cfg,
    input  logic          entry,
    input  logic [1:0]    clr,
    output logic          irq_thr,
    output logic          irq_tmo
);
    typedef struct packed {
        logic          thr;
        logic          tmo;
        logic [TW-1:0] cnt;
    } irq_st_t;

    irq_st_t st_d, st_q;

    logic thr_cond;
    logic tmo_hit;
    logic tmo_on;

    always_comb begin
        thr_cond = (dir == DIR_P2M) ? (level >= thresh) : (level < thresh);
        tmo_on   = (tmo_cfg != '0);
        tmo_hit  = !entry && tmo_on && (st_q.cnt < tmo_cfg)
                   && ((st_q.cnt + TW'(1)) == tmo_cfg);

        st_d = st_q;
        if (entry || !tmo_on)       st_d.cnt = '0;
        else if (st_q.cnt < tmo_cfg) st_d.cnt = st_q.cnt + TW'(1);

        // Setting wins over a clear in the same cycle
        st_d.thr = (st_q.thr && !clr[IRQ_THR_BIT]) || thr_cond;
        st_d.tmo = (st_q.tmo && !clr[IRQ_TMO_BIT]) || tmo_hit;

        irq_thr = st_q.thr;
        irq_tmo = st_q.tmo;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6, R7, R8: a true threshold condition always lands in the flag
    p_thr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        thr_cond |=> irq_thr);

    // R10: the timeout flag only rises while a nonzero limit is programmed
    p_tmo_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_tmo) |-> ($past(tmo_cfg) != '0));

    // R9: a clear without a concurrent hit drops the timeout flag
    p_tmo_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[IRQ_TMO_BIT] && !tmo_hit) |=> !irq_tmo);

    // R9: an entry restarts the idle count
    p_cnt_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        entry |=> (st_q.cnt == '0));

endmodule

// File: rtl/vfifo_ptr_engine.sv
module vfifo_ptr_engine
    import vfifo_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int AW         = 32,
    parameter int UNIT_BYTES = 4,
    parameter int TW         = 16,
    localparam int PW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_dir,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_fix_addr,
    input  logic [PW-1:0] cfg_thresh,
    input  logic [TW-1:0] cfg_timeout,
    input  logic          sw_ptr_wr,
    input  logic [PW-1:0] sw_ptr_wdata,
    input  logic [1:0]    irq_clr,
    input  logic          per_req,
    input  logic          xfer_gnt,
    output logic          xfer_req,
    output logic          xfer_to_mem,
    output logic [AW-1:0] xfer_src,
    output logic [AW-1:0] xfer_dst,
    output logic [PW-1:0] hw_ptr,
    output logic [PW-1:0] fill_level,
    output logic          fifo_full,
    output logic          fifo_empty,
    output logic          irq_thr,
    output logic          irq_tmo
);
    vf_dir_e dir;
    logic    entry;

    assign dir = vf_dir_e'(cfg_dir);

    vfifo_ptr_ctl #(
        .DEPTH      (DEPTH),
        .AW         (AW),
        .UNIT_BYTES (UNIT_BYTES)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir      (dir),
        .base     (cfg_base),
        .fix_addr (cfg_fix_addr),
        .sw_wr    (sw_ptr_wr),
        .sw_wdata (sw_ptr_wdata),
        .per_req  (per_req),
        .gnt      (xfer_gnt),
        .req      (xfer_req),
        .to_mem   (xfer_to_mem),
        .src      (xfer_src),
        .dst      (xfer_dst),
        .hw_ptr   (hw_ptr),
        .level    (fill_level),
        .full     (fifo_full),
        .empty    (fifo_empty),
        .entry    (entry)
    );

    vfifo_irq_ctl #(
        .PW (PW),
        .TW (TW)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir     (dir),
        .level   (fill_level),
        .thresh  (cfg_thresh),
        .tmo_cfg (cfg_timeout),
        .entry   (entry),
        .clr     (irq_clr),
        .irq_thr (irq_thr),
        .irq_tmo (irq_tmo)
    );

    // R11: full and empty are exclusive
    p_full_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

endmodule

// File: tb/sim_vfifo_ptr_engine.sv
`timescale 1ns/1ps
module sim_vfifo_ptr_engine;
    localparam int DEPTH = 8;
    localparam int AW    = 32;
    localparam int UB    = 4;
    localparam int TW    = 16;
    localparam int PW    = $clog2(DEPTH) + 1;
    localparam logic [AW-1:0] BASE = 32'h1000_0000;
    localparam logic [AW-1:0] FIX  = 32'h4000_0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_dir = 1'b0;
    logic [PW-1:0] cfg_thresh = '0;
    logic [TW-1:0] cfg_timeout = '0;
    logic sw_ptr_wr = 1'b0;
    logic [PW-1:0] sw_ptr_wdata = '0;
    logic [1:0] irq_clr = '0;
    logic per_req = 1'b0;
    logic xfer_gnt = 1'b0;
    logic xfer_req, xfer_to_mem, fifo_full, fifo_empty, irq_thr, irq_tmo;
    logic [AW-1:0] xfer_src, xfer_dst;
    logic [PW-1:0] hw_ptr, fill_level;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    vfifo_ptr_engine #(.DEPTH(DEPTH), .AW(AW), .UNIT_BYTES(UB), .TW(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_dir(cfg_dir), .cfg_base(BASE),
        .cfg_fix_addr(FIX), .cfg_thresh(cfg_thresh), .cfg_timeout(cfg_timeout),
        .sw_ptr_wr(sw_ptr_wr), .sw_ptr_wdata(sw_ptr_wdata), .irq_clr(irq_clr),
        .per_req(per_req), .xfer_gnt(xfer_gnt), .xfer_req(xfer_req),
        .xfer_to_mem(xfer_to_mem), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
        .hw_ptr(hw_ptr), .fill_level(fill_level), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .irq_thr(irq_thr), .irq_tmo(irq_tmo)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic dir, input int thr, input int tmo);
        @(negedge clk);
        per_req = 0; xfer_gnt = 1; sw_ptr_wr = 0; irq_clr = 0;
        cfg_dir = dir;
        cfg_thresh = PW'(thr);
        cfg_timeout = TW'(tmo);
        rst_n = 0;
        tick();
        tick();
        rst_n = 1;
    endtask

    task automatic sw_write(input int v);
        sw_ptr_wr = 1; sw_ptr_wdata = PW'(v);
        tick();
        sw_ptr_wr = 0;
    endtask

    task automatic clear(input logic [1:0] m);
        irq_clr = m;
        tick();
        irq_clr = 0;
    endtask

    task automatic t_reset();
        do_reset(0, 4, 0);
        chk("R1", "hw_ptr", hw_ptr, 0);
        chk("R1", "level", fill_level, 0);
        chk("R1", "empty", fifo_empty, 1);
        chk("R1", "full", fifo_full, 0);
        chk("R1", "irq_thr", irq_thr, 0);
        chk("R1", "irq_tmo", irq_tmo, 0);
    endtask

    task automatic t_p2m_fill();
        per_req = 1;
        for (int i = 0; i < DEPTH; i++) begin
            chk("R5", "p2m src", xfer_src, FIX);
            chk("R5", "p2m dst", xfer_dst, BASE + i * UB);
            chk("R5", "to_mem", xfer_to_mem, 1);
            tick();
            chk("R3", "p2m level", fill_level, i + 1);
            chk("R6", "thr ge", irq_thr, (i >= 4) ? 1 : 0);
        end
        chk("R11", "full", fifo_full, 1);
        chk("R2", "wrap bit set", hw_ptr, 8);
        chk("R3", "stall req", xfer_req, 0);
        tick();
        chk("R3", "hw held on full", hw_ptr, 8);
        per_req = 0;
        // R8: clear while the condition is still true keeps the flag
        clear(2'b01);
        chk("R8", "clear vs set", irq_thr, 1);
        sw_write(6);
        chk("R3", "level after read", fill_level, 2);
        chk("R8", "sticky", irq_thr, 1);
        clear(2'b01);
        chk("R8", "cleared", irq_thr, 0);
        tick();
        chk("R6", "below thr stays low", irq_thr, 0);
    endtask

    task automatic t_p2m_wrap();
        per_req = 1;
        for (int k = 0; k < 6; k++) begin
            chk("R2", "wrapped dst", xfer_dst, BASE + k * UB);
            tick();
            chk("R2", "hw after wrap", hw_ptr, 8 + k + 1);
        end
        per_req = 0;
        chk("R11", "full with wrap", fifo_full, 1);
        chk("R3", "level full", fill_level, 8);
        sw_write(14);
        chk("R11", "empty", fifo_empty, 1);
        chk("R3", "level empty", fill_level, 0);
    endtask

    task automatic t_m2p();
        do_reset(1, 3, 0);
        chk("R1", "m2p reset empty", fifo_empty, 1);
        per_req = 1;
        chk("R4", "stall on empty", xfer_req, 0);
        tick();
        chk("R4", "hw held on empty", hw_ptr, 0);
        chk("R7", "thr lt", irq_thr, 1);
        per_req = 0;
        sw_write(5);
        chk("R4", "m2p level", fill_level, 5);
        clear(2'b01);
        chk("R7", "thr cleared", irq_thr, 0);
        per_req = 1;
        for (int i = 0; i < 5; i++) begin
            chk("R5", "m2p src", xfer_src, BASE + i * UB);
            chk("R5", "m2p dst", xfer_dst, FIX);
            chk("R5", "m2p dir", xfer_to_mem, 0);
            tick();
            chk("R4", "drain level", fill_level, 5 - i - 1);
            chk("R7", "thr lt track", irq_thr, ((5 - i) < 3) ? 1 : 0);
        end
        chk("R4", "stall drained", xfer_req, 0);
        chk("R11", "empty drained", fifo_empty, 1);
        per_req = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic t_timeout();
        do_reset(0, 7, 5);
        per_req = 1; tick(); per_req = 0;
        idle(4);
        chk("R9", "tmo early", irq_tmo, 0);
        idle(1);
        chk("R9", "tmo at limit", irq_tmo, 1);
        clear(2'b10);
        chk("R9", "tmo cleared", irq_tmo, 0);
        idle(10);
        chk("R9", "tmo once", irq_tmo, 0);
        per_req = 1; tick(); per_req = 0;
        idle(3);
        per_req = 1; tick(); per_req = 0;
        idle(4);
        chk("R9", "restart by entry", irq_tmo, 0);
        idle(1);
        chk("R9", "tmo after restart", irq_tmo, 1);
        clear(2'b10);
        per_req = 1; tick(); per_req = 0;
        idle(4);
        irq_clr = 2'b10;
        tick();
        irq_clr = 0;
        chk("R8", "tmo set beats clear", irq_tmo, 1);
        // memory to peripheral: a software write is the entry
        do_reset(1, 0, 3);
        sw_write(2);
        idle(2);
        chk("R9", "m2p tmo early", irq_tmo, 0);
        idle(1);
        chk("R9", "m2p tmo", irq_tmo, 1);
    endtask

    task automatic t_tmo_off();
        do_reset(0, 7, 0);
        per_req = 1; tick(); per_req = 0;
        idle(40);
        chk("R10", "tmo disabled", irq_tmo, 0);
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_p2m_fill();
        t_p2m_wrap();
        t_m2p();
        t_timeout();
        t_tmo_off();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule